// File: doc/BRIEF.md
# Branch and Call Sequencer

This block decides where an 8-bit processor with a 16-bit address space goes next. It is handed one decoded instruction at a time: its flow class, the opcode byte, a 16-bit immediate, the zero and carry flags, the HL pair, and the sequential PC. The sequential PC already points past any operand bytes. In the following cycle it presents the next PC and the number of machine cycles the instruction took. When the instruction needs the stack, it also presents a stack write or the updated stack pointer.

The block owns the stack pointer and the interrupt master enable. A call or restart pushes the return address. A return pops the return address through a combinational read port that memory answers in the same cycle. The enable instruction only arms the interrupt enable, so the instruction that follows it still runs with interrupts masked. The disable instruction clears the enable and cancels any armed enable. Return-from-interrupt sets the enable directly.

Top module: `flow_seq`

## Requirements
- R1: The condition is chosen by opcode bits [4:3]: 00 = zero clear, 01 = zero set, 10 = carry clear, 11 = carry set. It applies only when `in_cond_en` is 1 and the class is JP (kind 1), JR (2), CALL (3) or RET (4). With `in_cond_en` at 0 these classes are always taken.
- R2: JP (kind 1) loads `in_imm` when taken and costs 4 cycles. When not taken it keeps `in_seq_pc` and costs 3 cycles. The unconditional form costs 4.
- R3: JR (kind 2) loads `in_seq_pc` plus the sign-extended `in_imm[7:0]`, wrapping modulo 2^16, and costs 3 cycles. When not taken it keeps `in_seq_pc` and costs 2.
- R4: CALL (kind 3), when taken, pushes `in_seq_pc`, loads `in_imm` and costs 6 cycles. When not taken it costs 3 and leaves the stack untouched.
- R5: RET (kind 4), when taken, loads `pop_rd_data` and raises SP by 2. The conditional form costs 5 taken and 2 not taken, and the unconditional form costs 4. RETI (kind 5) always pops and costs 4.
- R6: RST (kind 6) pushes `in_seq_pc`, loads the vector `in_opcode & 0x38` and costs 4 cycles.
- R7: JPHL (kind 7) loads `in_hl` and costs 1 cycle.
- R8: After EI (kind 8), `ime` stays 0 through the next instruction and becomes 1 once that instruction completes.
- R9: DI (kind 9) clears `ime` and cancels a pending EI.
- R10: RETI sets `ime` to 1 as it completes.
- R11: After reset, `pc_next` is 0, `sp` is 0xFFFE, and `ime`, `done` and `push_wr_en` are 0.
- R12: A push lowers SP by 2 and writes the 16-bit word at `push_wr_addr` = SP-2, so the high byte lands at SP-1. A pop reads the word at `pop_rd_addr` = SP, with the low byte at SP.
- R13: Any other class, including kinds 0 and 10 to 15, yields `in_seq_pc` in 1 cycle with no stack access. With `in_valid` low, `done` is 0 and `pc_next` and `sp` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_kind | input | 4 | Flow class code |
| in_cond_en | input | 1 | Instruction is the conditional form |
| in_opcode | input | 8 | Opcode byte (condition bits, restart vector) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| in_imm | input | 16 | Immediate operand |
| in_seq_pc | input | 16 | PC after opcode and operands |
| in_hl | input | 16 | HL register pair |
| pop_rd_en | output | 1 | Stack read request |
| pop_rd_addr | output | 16 | Stack read address |
| pop_rd_data | input | 16 | Word read from the stack |
| push_wr_en | output | 1 | Stack write strobe |
| push_wr_addr | output | 16 | Address of the low byte written |
| push_wr_data | output | 16 | Return address written |
| pc_next | output | 16 | Next program counter |
| sp | output | 16 | Stack pointer |
| cycles | output | 3 | Machine cycles of the last instruction |
| done | output | 1 | Result valid pulse |
| ime | output | 1 | Interrupt master enable |

## Verification
Each conditional class is run with all four condition codes under flag values that make the condition both true and false. A wrong bit-to-condition mapping or a swapped taken/not-taken cycle count therefore shows up as a wrong PC or count. Relative jumps use negative, positive and wrapping displacements, which exposes zero-extension and width faults. Several restart opcodes land on distinct vectors, which separates a correct mask from a constant or shifted one. Interrupt-enable sequences cover EI followed by an ordinary instruction, EI followed by DI, and RETI from the disabled state, which separates the one-instruction delay from an immediate enable.

// File: rtl/flow_pkg.sv
package flow_pkg;
    localparam int unsigned FLOW_AW   = 16;
    localparam int unsigned FLOW_BW   = 8;
    localparam int unsigned CYC_W     = 3;
    localparam int unsigned STK_STEP  = FLOW_AW / FLOW_BW;
    localparam logic [FLOW_BW-1:0] VEC_MASK = 8'h38;

    typedef enum logic [3:0] {
        K_OTHER = 4'd0,
        K_JP    = 4'd1,
        K_JR    = 4'd2,
        K_CALL  = 4'd3,
        K_RET   = 4'd4,
        K_RETI  = 4'd5,
        K_RST   = 4'd6,
        K_JPHL  = 4'd7,
        K_EI    = 4'd8,
        K_DI    = 4'd9
    } flow_kind_e;

    typedef struct packed {
        logic [FLOW_AW-1:0] pc;
        logic [FLOW_AW-1:0] sp;
        logic [CYC_W-1:0]   cyc;
        logic               done;
        logic               wr_en;
        logic [FLOW_AW-1:0] wr_addr;
        logic [FLOW_AW-1:0] wr_data;
    } flow_state_t;

    typedef struct packed {
        logic ime;
        logic pend;
    } ime_state_t;
endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval (
    input  logic [1:0] sel,
    input  logic       cond_en,
    input  logic       flag_z,
    input  logic       flag_c,
    output logic       taken
);
    logic hit;

    always_comb begin
        case (sel)
            2'b00:   hit = !flag_z;
            2'b01:   hit = flag_z;
            2'b10:   hit = !flag_c;
            default: hit = flag_c;
        endcase
        taken = cond_en ? hit : 1'b1;
    end
endmodule

// File: rtl/flow_cycle_table.sv
module flow_cycle_table
    import flow_pkg::*;
#(
    parameter int unsigned JP_T   = 4,
    parameter int unsigned JP_N   = 3,
    parameter int unsigned JR_T   = 3,
    parameter int unsigned JR_N   = 2,
    parameter int unsigned CALL_T = 6,
    parameter int unsigned CALL_N = 3,
    parameter int unsigned RETC_T = 5,
    parameter int unsigned RETC_N = 2,
    parameter int unsigned RET_U  = 4,
    parameter int unsigned RETI_C = 4,
    parameter int unsigned RST_C  = 4,
    parameter int unsigned BASE_C = 1
) (
    input  flow_kind_e       kind,
    input  logic             cond_en,
    input  logic             taken,
    output logic [CYC_W-1:0] cyc
);
    always_comb begin
        case (kind)
            K_JP:    cyc = taken ? CYC_W'(JP_T)   : CYC_W'(JP_N);
            K_JR:    cyc = taken ? CYC_W'(JR_T)   : CYC_W'(JR_N);
            K_CALL:  cyc = taken ? CYC_W'(CALL_T) : CYC_W'(CALL_N);
            K_RET:   cyc = !cond_en ? CYC_W'(RET_U)
                         : (taken ? CYC_W'(RETC_T) : CYC_W'(RETC_N));
            K_RETI:  cyc = CYC_W'(RETI_C);
            K_RST:   cyc = CYC_W'(RST_C);
            default: cyc = CYC_W'(BASE_C);
        endcase
    end
endmodule

// File: rtl/flow_ime_ctrl.sv
module flow_ime_ctrl
    import flow_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  flow_kind_e kind,
    output logic       ime,
    output logic       pend
);
    ime_state_t ist_d, ist_q;

    always_comb begin
        ist_d = ist_q;
        if (step) begin
            case (kind)
                K_EI: ist_d.pend = 1'b1;
                K_DI: begin
                    ist_d.ime  = 1'b0;
                    ist_d.pend = 1'b0;
                end
                K_RETI: begin
                    ist_d.ime  = 1'b1;
                    ist_d.pend = 1'b0;
                end
                default: begin
                    if (ist_q.pend) begin
                        ist_d.ime  = 1'b1;
                        ist_d.pend = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ist_q <= '0;
        else     ist_q <= ist_d;
    end

    assign ime  = ist_q.ime;
    assign pend = ist_q.pend;

    // R9: disable clears the enable and the armed enable
    a_r9_di_clears: assert property (@(posedge clk) disable iff (rst)
        (step && kind == K_DI) |=> (!ime && !pend));
    // R8: the instruction right after EI still sees interrupts masked
    a_r8_ei_delayed: assert property (@(posedge clk) disable iff (rst)
        (step && kind == K_EI && !ime) |=> !ime);
    // R10: return-from-interrupt enables
    a_r10_reti_sets: assert property (@(posedge clk) disable iff (rst)
        (step && kind == K_RETI) |=> ime);
endmodule

// File: rtl/flow_seq.sv
module flow_seq
    import flow_pkg::*;
#(
    parameter logic [FLOW_AW-1:0] SP_RESET = 16'hFFFE,
    parameter logic [FLOW_AW-1:0] PC_RESET = 16'h0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [3:0]         in_kind,
    input  logic               in_cond_en,
    input  logic [FLOW_BW-1:0] in_opcode,
    input  logic               flag_z,
    input  logic               flag_c,
    input  logic [FLOW_AW-1:0] in_imm,
    input  logic [FLOW_AW-1:0] in_seq_pc,
    input  logic [FLOW_AW-1:0] in_hl,
    output logic               pop_rd_en,
    output logic [FLOW_AW-1:0] pop_rd_addr,
    input  logic [FLOW_AW-1:0] pop_rd_data,
    output logic               push_wr_en,
    output logic [FLOW_AW-1:0] push_wr_addr,
    output logic [FLOW_AW-1:0] push_wr_data,
    output logic [FLOW_AW-1:0] pc_next,
    output logic [FLOW_AW-1:0] sp,
    output logic [CYC_W-1:0]   cycles,
    output logic               done,
    output logic               ime
);
    localparam logic [FLOW_AW-1:0] STEP = FLOW_AW'(STK_STEP);
    localparam int unsigned EXT_W = FLOW_AW - FLOW_BW;

    flow_state_t st_d, st_q;
    flow_kind_e  kind;
    logic        cond_applies;
    logic        taken;
    logic [CYC_W-1:0] cyc_w;
    logic [FLOW_AW-1:0] rel_off;
    logic [FLOW_AW-1:0] vec_addr;
    logic        ime_pend;

    always_comb begin
        if (in_kind <= 4'd9) kind = flow_kind_e'(in_kind);
        else                 kind = K_OTHER;
        cond_applies = in_cond_en &&
            (kind == K_JP || kind == K_JR || kind == K_CALL || kind == K_RET);
    end

    flow_cond_eval u_cond (
        .sel     (in_opcode[4:3]),
        .cond_en (cond_applies),
        .flag_z  (flag_z),
        .flag_c  (flag_c),
        .taken   (taken)
    );

    flow_cycle_table u_cyc (
        .kind    (kind),
        .cond_en (cond_applies),
        .taken   (taken),
        .cyc     (cyc_w)
    );

    flow_ime_ctrl u_ime (
        .clk  (clk),
        .rst  (rst),
        .step (in_valid),
        .kind (kind),
        .ime  (ime),
        .pend (ime_pend)
    );

    assign rel_off  = {{EXT_W{in_imm[FLOW_BW-1]}}, in_imm[FLOW_BW-1:0]};
    assign vec_addr = {{EXT_W{1'b0}}, in_opcode & VEC_MASK};

    always_comb begin
        pop_rd_en   = in_valid && ((kind == K_RET && taken) || kind == K_RETI);
        pop_rd_addr = st_q.sp;
    end

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.wr_en = 1'b0;
        if (in_valid) begin
            st_d.done = 1'b1;
            st_d.cyc  = cyc_w;
            st_d.pc   = in_seq_pc;
            case (kind)
                K_JP: if (taken) st_d.pc = in_imm;
                K_JR: if (taken) st_d.pc = in_seq_pc + rel_off;
                K_CALL: begin
                    if (taken) begin
                        st_d.wr_en   = 1'b1;
                        st_d.wr_addr = st_q.sp - STEP;
                        st_d.wr_data = in_seq_pc;
                        st_d.sp      = st_q.sp - STEP;
                        st_d.pc      = in_imm;
                    end
                end
                K_RST: begin
                    st_d.wr_en   = 1'b1;
                    st_d.wr_addr = st_q.sp - STEP;
                    st_d.wr_data = in_seq_pc;
                    st_d.sp      = st_q.sp - STEP;
                    st_d.pc      = vec_addr;
                end
                K_RET, K_RETI: begin
                    if (pop_rd_en) begin
                        st_d.pc = pop_rd_data;
                        st_d.sp = st_q.sp + STEP;
                    end
                end
                K_JPHL: st_d.pc = in_hl;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.pc      <= PC_RESET;
            st_q.sp      <= SP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_wr_en   = st_q.wr_en;
    assign push_wr_addr = st_q.wr_addr;
    assign push_wr_data = st_q.wr_data;
    assign pc_next      = st_q.pc;
    assign sp           = st_q.sp;
    assign cycles       = st_q.cyc;
    assign done         = st_q.done;

    // R12: after a push the stack pointer rests on the written low byte
    a_r12_push_sp: assert property (@(posedge clk) disable iff (rst)
        push_wr_en |-> (push_wr_addr == sp));
    // R12: a pop raises the stack pointer by one word
    a_r12_pop_step: assert property (@(posedge clk) disable iff (rst)
        pop_rd_en |=> (sp == $past(pop_rd_addr) + STEP));
    // R6: restart lands on one of the eight aligned vectors
    a_r6_vector: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == K_RST) |=> ((pc_next & ~16'h0038) == 16'h0000));
    // R2..R7: every completed instruction reports 1 to 6 cycles
    a_r2_cyc_range: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles != 3'd0 && cycles <= 3'd6));
    // R13: no result without an instruction
    a_r13_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!done && !push_wr_en && $stable(pc_next)));
    // R1: an unconditional form never stays on the sequential path for JP
    a_r1_uncond_jp: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == K_JP && !in_cond_en) |=> (cycles == 3'd4));
endmodule

// File: tb/flow_seq_test.sv
module flow_seq_test;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [3:0]  kind;
        logic        ce;
        logic [7:0]  op;
        logic        z;
        logic        c;
        logic [15:0] imm;
        logic [15:0] spc;
        logic [15:0] rd;
        logic [15:0] pc_exp;
        logic [2:0]  cyc;
        logic [1:0]  stk;   // 0 none, 1 push, 2 pop
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        // R1 R2: JP with each condition code
        '{4'd1,1'b1,8'hC2,1'b0,1'b0,16'h1234,16'h0103,16'h0000,16'h1234,3'd4,2'd0,4'd2},
        '{4'd1,1'b1,8'hC2,1'b1,1'b0,16'h1234,16'h0103,16'h0000,16'h0103,3'd3,2'd0,4'd2},
        '{4'd1,1'b1,8'hCA,1'b1,1'b0,16'h2222,16'h0106,16'h0000,16'h2222,3'd4,2'd0,4'd1},
        '{4'd1,1'b1,8'hD2,1'b0,1'b1,16'h3333,16'h0109,16'h0000,16'h0109,3'd3,2'd0,4'd1},
        '{4'd1,1'b1,8'hDA,1'b0,1'b1,16'h4444,16'h010C,16'h0000,16'h4444,3'd4,2'd0,4'd1},
        '{4'd1,1'b0,8'hC3,1'b1,1'b1,16'h5555,16'h010F,16'h0000,16'h5555,3'd4,2'd0,4'd2},
        // R3: relative jumps
        '{4'd2,1'b1,8'h20,1'b0,1'b0,16'h00FE,16'h0200,16'h0000,16'h01FE,3'd3,2'd0,4'd3},
        '{4'd2,1'b1,8'h38,1'b0,1'b0,16'h0010,16'h0200,16'h0000,16'h0200,3'd2,2'd0,4'd3},
        '{4'd2,1'b0,8'h18,1'b1,1'b0,16'h007F,16'h0200,16'h0000,16'h027F,3'd3,2'd0,4'd3},
        '{4'd2,1'b0,8'h18,1'b0,1'b0,16'h0020,16'hFFF0,16'h0000,16'h0010,3'd3,2'd0,4'd3},
        // R4: calls
        '{4'd3,1'b1,8'hCC,1'b1,1'b0,16'h4000,16'h0150,16'h0000,16'h4000,3'd6,2'd1,4'd4},
        '{4'd3,1'b1,8'hD4,1'b0,1'b1,16'h4100,16'h0150,16'h0000,16'h0150,3'd3,2'd0,4'd4},
        '{4'd3,1'b0,8'hCD,1'b0,1'b0,16'h5000,16'h4003,16'h0000,16'h5000,3'd6,2'd1,4'd4},
        // R5: returns
        '{4'd4,1'b1,8'hC0,1'b1,1'b0,16'h0000,16'h5001,16'h9999,16'h5001,3'd2,2'd0,4'd5},
        '{4'd4,1'b1,8'hD8,1'b0,1'b1,16'h0000,16'h5002,16'h4003,16'h4003,3'd5,2'd2,4'd5},
        '{4'd4,1'b0,8'hC9,1'b0,1'b0,16'h0000,16'h4004,16'h0153,16'h0153,3'd4,2'd2,4'd5},
        // R6: restart vectors
        '{4'd6,1'b0,8'hFF,1'b0,1'b0,16'h0000,16'h0300,16'h0000,16'h0038,3'd4,2'd1,4'd6},
        '{4'd6,1'b0,8'hC7,1'b0,1'b0,16'h0000,16'h0039,16'h0000,16'h0000,3'd4,2'd1,4'd6},
        '{4'd6,1'b0,8'hEF,1'b0,1'b0,16'h0000,16'h0001,16'h0000,16'h0028,3'd4,2'd1,4'd6},
        // R7: jump to HL (bench drives HL = 8ABC)
        '{4'd7,1'b1,8'hE9,1'b0,1'b0,16'h0000,16'h0029,16'h0000,16'h8ABC,3'd1,2'd0,4'd7},
        // R13: ordinary instruction, and an unused class code
        '{4'd12,1'b1,8'h00,1'b0,1'b0,16'h7777,16'h0401,16'h0000,16'h0401,3'd1,2'd0,4'd13}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_kind = '0;
    logic        in_cond_en = 1'b0;
    logic [7:0]  in_opcode = '0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic [15:0] in_imm = '0;
    logic [15:0] in_seq_pc = '0;
    logic [15:0] in_hl = 16'h8ABC;
    logic [15:0] pop_rd_data = '0;
    logic        pop_rd_en;
    logic [15:0] pop_rd_addr;
    logic        push_wr_en;
    logic [15:0] push_wr_addr;
    logic [15:0] push_wr_data;
    logic [15:0] pc_next;
    logic [15:0] sp;
    logic [2:0]  cycles;
    logic        done;
    logic        ime;

    int checks = 0;
    int errors = 0;
    logic        rd_en_s;
    logic [15:0] rd_addr_s;
    logic [15:0] sp_exp;

    flow_seq uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_cond_en(in_cond_en), .in_opcode(in_opcode), .flag_z(flag_z),
        .flag_c(flag_c), .in_imm(in_imm), .in_seq_pc(in_seq_pc), .in_hl(in_hl),
        .pop_rd_en(pop_rd_en), .pop_rd_addr(pop_rd_addr), .pop_rd_data(pop_rd_data),
        .push_wr_en(push_wr_en), .push_wr_addr(push_wr_addr),
        .push_wr_data(push_wr_data), .pc_next(pc_next), .sp(sp),
        .cycles(cycles), .done(done), .ime(ime)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] k, input logic ce, input logic [7:0] op,
                        input logic z, input logic c, input logic [15:0] imm,
                        input logic [15:0] spc, input logic [15:0] rd);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_cond_en = ce; in_opcode = op;
        flag_z = z; flag_c = c; in_imm = imm; in_seq_pc = spc; pop_rd_data = rd;
        #1;
        rd_en_s = pop_rd_en;
        rd_addr_s = pop_rd_addr;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk(pc_next == 16'h0000, "R11", "pc", 32'(pc_next), 32'h0);
        chk(sp == 16'hFFFE, "R11", "sp", 32'(sp), 32'hFFFE);
        chk(!ime && !done && !push_wr_en, "R11", "ime/done/wr",
            {29'd0, ime, done, push_wr_en}, 32'h0);
        sp_exp = 16'hFFFE;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string rq;
            v = VECS[i];
            rq = $sformatf("R%0d", v.rq);
            step(v.kind, v.ce, v.op, v.z, v.c, v.imm, v.spc, v.rd);
            chk(pc_next == v.pc_exp, rq, "pc", 32'(pc_next), 32'(v.pc_exp));
            chk(done && cycles == v.cyc, rq, "cycles", 32'(cycles), 32'(v.cyc));
            // R12: stack traffic and layout
            chk(rd_en_s == (v.stk == 2'd2), "R12", "pop req", 32'(rd_en_s), 32'(v.stk == 2'd2));
            if (v.stk == 2'd2) begin
                chk(rd_addr_s == sp_exp, "R12", "pop addr", 32'(rd_addr_s), 32'(sp_exp));
                sp_exp = sp_exp + 16'd2;
            end
            chk(push_wr_en == (v.stk == 2'd1), "R12", "push strobe",
                32'(push_wr_en), 32'(v.stk == 2'd1));
            if (v.stk == 2'd1) begin
                chk(push_wr_addr == sp_exp - 16'd2, "R12", "push addr",
                    32'(push_wr_addr), 32'(sp_exp - 16'd2));
                chk(push_wr_data == v.spc, "R4", "push data",
                    32'(push_wr_data), 32'(v.spc));
                sp_exp = sp_exp - 16'd2;
            end
            chk(sp == sp_exp, "R12", "sp", 32'(sp), 32'(sp_exp));
        end

        // R13: idle cycle holds state and produces no result
        @(negedge clk);
        chk(!done && !push_wr_en, "R13", "idle done", {30'd0, done, push_wr_en}, 32'h0);
        chk(pc_next == 16'h0401 && sp == sp_exp, "R13", "idle hold", 32'(pc_next), 32'h0401);

        // R8: enable is delayed by one instruction
        step(4'd8, 1'b0, 8'hFB, 1'b0, 1'b0, 16'h0, 16'h0501, 16'h0);
        chk(ime == 1'b0, "R8", "ime after EI", 32'(ime), 32'h0);
        step(4'd0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0, 16'h0502, 16'h0);
        chk(ime == 1'b1, "R8", "ime after next", 32'(ime), 32'h1);

        // R9: DI clears the enable, and a pending EI is cancelled
        step(4'd9, 1'b0, 8'hF3, 1'b0, 1'b0, 16'h0, 16'h0503, 16'h0);
        chk(ime == 1'b0, "R9", "ime after DI", 32'(ime), 32'h0);
        step(4'd8, 1'b0, 8'hFB, 1'b0, 1'b0, 16'h0, 16'h0504, 16'h0);
        step(4'd9, 1'b0, 8'hF3, 1'b0, 1'b0, 16'h0, 16'h0505, 16'h0);
        step(4'd0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0, 16'h0506, 16'h0);
        chk(ime == 1'b0, "R9", "pending cancelled", 32'(ime), 32'h0);
        chk(cycles == 3'd1 && pc_next == 16'h0506, "R13", "plain cycles", 32'(cycles), 32'h1);

        // R10 R5: RETI pops, costs 4 and enables at once
        step(4'd5, 1'b0, 8'hD9, 1'b0, 1'b0, 16'h0, 16'h0507, 16'h0ACE);
        chk(ime == 1'b1, "R10", "ime after RETI", 32'(ime), 32'h1);
        chk(pc_next == 16'h0ACE && cycles == 3'd4, "R5", "RETI pc", 32'(pc_next), 32'h0ACE);
        sp_exp = sp_exp + 16'd2;
        chk(sp == sp_exp, "R12", "RETI sp", 32'(sp), 32'(sp_exp));

        // R11: reset in mid-run restores the initial state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(sp == 16'hFFFE && !ime && pc_next == 16'h0, "R11", "re-reset",
            32'(sp), 32'hFFFE);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule